// File: doc/BRIEF.md
# Programmable receive frame rule matcher

This block examines the bytes of each received Ethernet frame against a table of match rules and produces a single accept or reject decision per frame. A rule picks one aligned 32-bit word of the frame by word offset. It masks that word bit by bit and compares it with a stored value. The first active rule that matches, in ascending table order, decides the frame's fate. Two neighbouring rules can be linked into one rule, so that a key straddling a word boundary is checked as two masked word compares that must both hold.

Rules are loaded through a one-cycle write port. Frames arrive one byte per valid cycle, with start and end markers. The block compares each word as its fourth byte arrives, so the decision is ready in the cycle right after the last byte. The final table slot is fixed as a catch-all accept rule, so every frame gets a decision. Choosing which offsets to inspect is left to the software that writes the table. For example, a key given relative to an IPv4 header is placed 14 bytes further into the frame.

Top module: `frame_rule_matcher`

## Requirements
- R1: A write with `wr_en` high and `wr_idx` below DEPTH-1 stores value, mask, word offset, link and both action flags into that slot at the next clock edge. A write to slot DEPTH-1 has no effect.
- R2: A rule's word at offset w consists of frame bytes 4w..4w+3, with byte 4w+k placed in bits 8k+7:8k. The rule matches when that word ANDed with the mask equals the stored value.
- R3: A rule whose word is not wholly received before the end of the frame, or lies at or beyond byte MAX_BYTES, does not match.
- R4: Rules are tried in ascending index order and the first active match decides. A rule with neither action flag set is inactive and is skipped.
- R5: A rule with its link flag set forms a pair with the next slot, and the pair matches only when both words match. The second slot supplies the action flags and is never evaluated on its own. A link flag in slot DEPTH-2 is ignored.
- R6: Slot DEPTH-1 is an all-pass rule with zero mask, zero value and the accept action. A frame that no other rule decides is accepted, whatever its length.
- R7: `dec_valid` is high for exactly one cycle: the cycle after the clock edge that takes the end-of-frame byte. It comes with exactly one of `dec_accept` and `dec_reject`. The result is reject when the deciding rule has its reject flag set (including when both flags are set), and accept otherwise. Outside that cycle both flags are low.
- R8: A byte with `in_sof` high is byte 0 of a new frame. All match state from earlier bytes is discarded, even when the earlier frame never saw its end marker.
- R9: After reset all slots below DEPTH-1 are inactive and unlinked, and the decision outputs are low.
- R10: A 32-bit key at byte offset B with r = B mod 4 not zero is expressed as a linked pair. The first slot uses word B/4, with mask and value shifted left by 8r bits. The second uses word B/4+1, with the key shifted right by 32-8r bits and the mask keeping only the low 8r bits. The pair matches exactly when all four key bytes are present and equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Rule write strobe |
| wr_idx | input | IDX_W | Slot being written |
| wr_value | input | 32 | Match value |
| wr_mask | input | 32 | Per-bit compare enable |
| wr_woff | input | WOFF_W | Word offset into the frame |
| wr_link | input | 1 | Pair this slot with the next one |
| wr_accept | input | 1 | Accept action flag |
| wr_reject | input | 1 | Reject action flag |
| in_valid | input | 1 | Frame byte present |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_byte | input | 8 | Frame byte |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_reject | output | 1 | Frame rejected |

## Verification
The assertions assume that the table is not rewritten while a frame is in flight. They also assume that every frame begins with a start-marked byte and that the end marker only appears on a valid byte. The bench holds to this by doing all rule writes between frames and driving whole frames with exactly one start byte and one end byte. The bench resets the block between scenarios rather than relying on rule overwrites. Under those conditions the bench sweeps every word offset with frame lengths on both sides of the word boundary, and every unaligned byte offset of a split key.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  // widest word offset the block supports (256 bytes / 4)
  localparam int RFM_WOFF_MAX_W = 6;

  typedef struct packed {
    logic [31:0]               value;
    logic [31:0]               mask;
    logic [RFM_WOFF_MAX_W-1:0] woff;
    logic                      link;
    logic                      accept;
    logic                      reject;
  } rfm_rule_t;
endpackage

// File: rtl/rfm_rule_table.sv
module rfm_rule_table #(
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 6,
  parameter int WOFF_W = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [IDX_W-1:0]                    wr_idx,
  input  logic [31:0]                         wr_value,
  input  logic [31:0]                         wr_mask,
  input  logic [WOFF_W-1:0]                   wr_woff,
  input  logic                                wr_link,
  input  logic                                wr_accept,
  input  logic                                wr_reject,
  output rfm_pkg::rfm_rule_t [DEPTH-2:0]      rules
);
  import rfm_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] PENULT   = IDX_W'(DEPTH - 2);

  rfm_rule_t [DEPTH-2:0] rules_q;
  logic                  wr_ok;

  assign wr_ok = wr_en && (wr_idx < LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        rules_q[i].link   <= 1'b0;
        rules_q[i].accept <= 1'b0;
        rules_q[i].reject <= 1'b0;
      end
    end else if (wr_ok) begin
      rules_q[wr_idx].value  <= wr_value;
      rules_q[wr_idx].mask   <= wr_mask;
      rules_q[wr_idx].woff   <= RFM_WOFF_MAX_W'(wr_woff);
      rules_q[wr_idx].link   <= wr_link && (wr_idx != PENULT);
      rules_q[wr_idx].accept <= wr_accept;
      rules_q[wr_idx].reject <= wr_reject;
    end
  end

  assign rules = rules_q;

  // R1
  table_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && (wr_idx < LAST_IDX) |=>
      (rules_q[$past(wr_idx)].value == $past(wr_value)) &&
      (rules_q[$past(wr_idx)].reject == $past(wr_reject)));
endmodule

// File: rtl/rfm_word_capture.sv
module rfm_word_capture #(
  parameter int BIDX_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [7:0]        in_byte,
  output logic              word_done,
  output logic [BIDX_W-3:0] word_idx,
  output logic [31:0]       word_data
);
  logic [BIDX_W-1:0] bidx_q;
  logic [BIDX_W-1:0] cur_idx;
  logic [7:0]        b0_q, b1_q, b2_q;

  assign cur_idx   = in_sof ? '0 : bidx_q;
  assign word_done = in_valid && (cur_idx[1:0] == 2'd3);
  assign word_idx  = cur_idx[BIDX_W-1:2];
  assign word_data = {in_byte, b2_q, b1_q, b0_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      bidx_q <= '0;
    end else if (in_valid) begin
      // saturate so that bytes past the window never alias low offsets
      bidx_q <= (&cur_idx) ? cur_idx : cur_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      case (cur_idx[1:0])
        2'd0:    b0_q <= in_byte;
        2'd1:    b1_q <= in_byte;
        2'd2:    b2_q <= in_byte;
        default: ;
      endcase
    end
  end

  // R8
  sof_restart_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_sof |=> bidx_q == BIDX_W'(1));
endmodule

// File: rtl/rfm_hit_tracker.sv
module rfm_hit_tracker #(
  parameter int DEPTH  = 64,
  parameter int WOFF_W = 4,
  parameter int WIDX_W = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  rfm_pkg::rfm_rule_t [DEPTH-2:0] rules,
  input  logic                           in_valid,
  input  logic                           in_sof,
  input  logic                           word_done,
  input  logic [WIDX_W-1:0]              word_idx,
  input  logic [31:0]                    word_data,
  output logic [DEPTH-2:0]               hit_now
);
  logic [DEPTH-2:0] hit_q;
  logic [DEPTH-2:0] hit_new;
  logic [DEPTH-2:0] hit_base;

  for (genvar g = 0; g < DEPTH - 1; g++) begin : g_cmp
    logic at_word;
    assign at_word    = word_idx == WIDX_W'(rules[g].woff[WOFF_W-1:0]);
    assign hit_new[g] = word_done && at_word &&
                        ((word_data & rules[g].mask) == rules[g].value);
  end

  assign hit_base = (in_valid && in_sof) ? '0 : hit_q;
  assign hit_now  = hit_base | hit_new;

  always_ff @(posedge clk) begin
    if (rst)           hit_q <= '0;
    else if (in_valid) hit_q <= hit_now;
  end

  // R8
  sof_clear_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_sof && !word_done |=> hit_q == '0);
endmodule

// File: rtl/rfm_decide.sv
module rfm_decide #(
  parameter int DEPTH = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  rfm_pkg::rfm_rule_t [DEPTH-2:0] rules,
  input  logic [DEPTH-2:0]               hit_now,
  input  logic                           fire,
  output logic                           dec_valid,
  output logic                           dec_accept,
  output logic                           dec_reject
);
  logic pick_reject;

  always_comb begin
    logic found;
    logic skip;
    found       = 1'b0;
    skip        = 1'b0;
    pick_reject = 1'b0;
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (skip) begin
        skip = 1'b0;
      end else if (rules[i].link && (i < DEPTH - 2)) begin
        if (!found && hit_now[i] && hit_now[i+1] &&
            (rules[i+1].accept || rules[i+1].reject)) begin
          found       = 1'b1;
          pick_reject = rules[i+1].reject;
        end
        skip = 1'b1;
      end else if (!found && hit_now[i] &&
                   (rules[i].accept || rules[i].reject)) begin
        found       = 1'b1;
        pick_reject = rules[i].reject;
      end
    end
    // no earlier decision: the fixed last slot accepts
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reject <= 1'b0;
    end else begin
      dec_valid  <= fire;
      dec_accept <= fire && !pick_reject;
      dec_reject <= fire && pick_reject;
    end
  end

  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_accept ^ dec_reject));
  // R7
  quiet_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !dec_accept && !dec_reject);
  // R7
  strobe_follows_eof_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> dec_valid);
  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !dec_valid);
endmodule

// File: rtl/frame_rule_matcher.sv
module frame_rule_matcher #(
  parameter int DEPTH     = 64,
  parameter int MAX_BYTES = 64,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int WORDS    = MAX_BYTES / 4,
  localparam int WOFF_W   = $clog2(WORDS),
  localparam int BIDX_W   = $clog2(MAX_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_value,
  input  logic [31:0]       wr_mask,
  input  logic [WOFF_W-1:0] wr_woff,
  input  logic              wr_link,
  input  logic              wr_accept,
  input  logic              wr_reject,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_byte,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              dec_reject
);
  localparam int WIDX_W = BIDX_W - 2;

  rfm_pkg::rfm_rule_t [DEPTH-2:0] rules;
  logic                           word_done;
  logic [WIDX_W-1:0]              word_idx;
  logic [31:0]                    word_data;
  logic [DEPTH-2:0]               hit_now;
  logic                           fire;

  assign fire = in_valid && in_eof;

  rfm_rule_table #(.DEPTH(DEPTH), .IDX_W(IDX_W), .WOFF_W(WOFF_W)) u_table (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_value(wr_value), .wr_mask(wr_mask), .wr_woff(wr_woff),
    .wr_link(wr_link), .wr_accept(wr_accept), .wr_reject(wr_reject),
    .rules(rules)
  );

  rfm_word_capture #(.BIDX_W(BIDX_W)) u_capture (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .in_byte(in_byte), .word_done(word_done), .word_idx(word_idx),
    .word_data(word_data)
  );

  rfm_hit_tracker #(.DEPTH(DEPTH), .WOFF_W(WOFF_W), .WIDX_W(WIDX_W)) u_hits (
    .clk(clk), .rst(rst), .rules(rules), .in_valid(in_valid),
    .in_sof(in_sof), .word_done(word_done), .word_idx(word_idx),
    .word_data(word_data), .hit_now(hit_now)
  );

  rfm_decide #(.DEPTH(DEPTH)) u_decide (
    .clk(clk), .rst(rst), .rules(rules), .hit_now(hit_now), .fire(fire),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reject(dec_reject)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !dec_valid && !dec_accept && !dec_reject);
endmodule

// File: tb/test_frame_rule_matcher.sv
module test_frame_rule_matcher;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int MAX_BYTES  = 32;
  localparam int WORDS      = MAX_BYTES / 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_value = '0;
  logic [31:0] wr_mask = '0;
  logic [2:0]  wr_woff = '0;
  logic        wr_link = 1'b0;
  logic        wr_accept = 1'b0;
  logic        wr_reject = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        dec_valid, dec_accept, dec_reject;

  int errors = 0;
  int checks = 0;

  // bench-side copy of the table and of the frame
  logic [31:0] m_val [DEPTH];
  logic [31:0] m_msk [DEPTH];
  int          m_wo  [DEPTH];
  logic        m_lk  [DEPTH];
  logic        m_ac  [DEPTH];
  logic        m_rj  [DEPTH];
  logic [7:0]  fb    [64];

  always #(CLK_PERIOD / 2) clk = ~clk;

  frame_rule_matcher #(.DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES)) i_frame_rule_matcher (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_value(wr_value),
    .wr_mask(wr_mask), .wr_woff(wr_woff), .wr_link(wr_link),
    .wr_accept(wr_accept), .wr_reject(wr_reject), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_byte(in_byte),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reject(dec_reject)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  task automatic do_reset();
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      m_lk[i] = 1'b0; m_ac[i] = 1'b0; m_rj[i] = 1'b0;
      m_val[i] = '0; m_msk[i] = '0; m_wo[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: outputs low after reset
    chk(!dec_valid && !dec_accept && !dec_reject, "R9 reset outputs",
        {dec_valid, dec_accept, dec_reject}, 0);
  endtask

  task automatic wr_rule(input int idx, input logic [31:0] val, input logic [31:0] msk,
                         input int wo, input bit lk, input bit ac, input bit rj);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_value = val; wr_mask = msk;
    wr_woff = 3'(wo); wr_link = lk; wr_accept = ac; wr_reject = rj;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < DEPTH - 1) begin
      m_val[idx] = val; m_msk[idx] = msk; m_wo[idx] = wo;
      m_lk[idx] = lk && (idx != DEPTH - 2); m_ac[idx] = ac; m_rj[idx] = rj;
    end
  endtask

  function automatic bit rule_hit(input int i, input int len);
    int w;
    logic [31:0] word;
    w = m_wo[i];
    if (!(4 * w + 3 < len && w < WORDS)) return 1'b0;
    word = {fb[4*w+3], fb[4*w+2], fb[4*w+1], fb[4*w]};
    return (word & m_msk[i]) == m_val[i];
  endfunction

  // expected outcome from the requirements: 1 = reject
  function automatic bit model_reject(input int len);
    int i;
    i = 0;
    while (i < DEPTH - 1) begin
      if (m_lk[i]) begin
        if (rule_hit(i, len) && rule_hit(i + 1, len) && (m_ac[i+1] || m_rj[i+1]))
          return m_rj[i+1];
        i += 2;
      end else begin
        if (rule_hit(i, len) && (m_ac[i] || m_rj[i])) return m_rj[i];
        i += 1;
      end
    end
    return 1'b0;
  endfunction

  task automatic send(input int len, input bit exp_rej, input string req);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (k == 0); in_eof = (k == len - 1); in_byte = fb[k];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    // R7: strobe in the cycle after the last byte, one outcome
    chk(dec_valid && (dec_reject == exp_rej) && (dec_accept == !exp_rej), req,
        {dec_valid, dec_accept, dec_reject}, {1'b1, !exp_rej, exp_rej});
    @(negedge clk);
    chk(!dec_valid && !dec_accept && !dec_reject, "R7 strobe one cycle",
        {dec_valid, dec_accept, dec_reject}, 0);
  endtask

  task automatic fill_frame(input int seed);
    for (int k = 0; k < 64; k++) fb[k] = 8'((k * 37 + seed * 11 + 5) & 8'hff);
  endtask

  initial begin
    logic [31:0] key;
    logic [31:0] wrd;
    do_reset();

    // R6: empty table, every length accepted
    fill_frame(1);
    for (int len = 1; len <= 12; len++) send(len, 1'b0, "R6 catch-all empty table");

    // R1 R6: write to last slot ignored
    wr_rule(DEPTH - 1, 32'h0, 32'h0, 0, 1'b0, 1'b0, 1'b1);
    send(8, 1'b0, "R1 last slot write ignored");

    // R2 R3: each word offset, lengths around the word end, two masks
    for (int w = 0; w < WORDS; w++) begin
      for (int mv = 0; mv < 2; mv++) begin
        do_reset();
        fill_frame(w + mv);
        wrd = {fb[4*w+3], fb[4*w+2], fb[4*w+1], fb[4*w]};
        if (mv == 0) wr_rule(0, wrd, 32'hffff_ffff, w, 1'b0, 1'b0, 1'b1);
        else wr_rule(0, wrd & 32'h00f0_ff0f, 32'h00f0_ff0f, w, 1'b0, 1'b0, 1'b1);
        for (int d = 3; d <= 5; d++) begin
          send(4 * w + d, model_reject(4 * w + d), "R3 word present vs length");
        end
        fb[4*w+1] = fb[4*w+1] ^ 8'h01;
        send(4 * w + 4, model_reject(4 * w + 4), "R2 masked compare");
      end
    end

    // R4 R7: priority and inactive rules
    do_reset();
    fill_frame(3);
    wrd = {fb[7], fb[6], fb[5], fb[4]};
    wr_rule(0, wrd, 32'hffff_ffff, 1, 1'b0, 1'b1, 1'b0);
    wr_rule(1, wrd, 32'hffff_ffff, 1, 1'b0, 1'b0, 1'b1);
    send(8, 1'b0, "R4 first match accept wins");
    wr_rule(0, wrd, 32'hffff_ffff, 1, 1'b0, 1'b0, 1'b0);
    send(8, 1'b1, "R4 inactive rule skipped");
    wr_rule(0, wrd, 32'hffff_ffff, 1, 1'b0, 1'b1, 1'b1);
    send(8, 1'b1, "R7 both flags reject");

    // R5 R10: split keys at every unaligned offset; B >= 14 are IPv4
    // header offsets B-14 shifted past the 14-byte Ethernet header
    key = 32'ha1b2_c3d4;
    for (int b = 1; b <= 27; b++) begin
      int r;
      r = b % 4;
      if (r == 0) continue;
      do_reset();
      fill_frame(b);
      for (int k = 0; k < 4; k++) fb[b + k] = key[8*k +: 8];
      wr_rule(2, key << (8 * r), 32'hffff_ffff << (8 * r), b / 4, 1'b1, 1'b0, 1'b0);
      wr_rule(3, key >> (32 - 8 * r), 32'hffff_ffff >> (32 - 8 * r), b / 4 + 1,
              1'b0, 1'b0, 1'b1);
      send(32, 1'b1, "R10 split key matches");
      fb[b] = fb[b] ^ 8'h80;
      send(32, 1'b0, "R5 continuation alone ignored");
      fb[b] = fb[b] ^ 8'h80;
      fb[b + 3] = fb[b + 3] ^ 8'h02;
      send(32, 1'b0, "R5 continuation must match");
    end

    // R5: link in slot DEPTH-2 ignored
    do_reset();
    fill_frame(9);
    wrd = {fb[3], fb[2], fb[1], fb[0]};
    wr_rule(DEPTH - 2, wrd, 32'hffff_ffff, 0, 1'b1, 1'b0, 1'b1);
    send(8, 1'b1, "R5 last link ignored");

    // R8: state cleared between frames and on a restart without an end
    do_reset();
    fill_frame(4);
    wrd = {fb[7], fb[6], fb[5], fb[4]};
    wr_rule(0, wrd, 32'hffff_ffff, 1, 1'b0, 1'b0, 1'b1);
    send(8, 1'b1, "R8 first frame rejects");
    send(4, 1'b0, "R8 match state cleared");
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (k == 0); in_eof = 1'b0; in_byte = fb[k];
    end
    send(5, 1'b0, "R8 restart discards hits");

    finish_run();
  end
endmodule